// File: doc/BRIEF.md
# Reliable Segment Selection Engine

This block chooses which segment each flow transmits next in a reliable transport. Data is divided into fixed segments before it reaches the engine, so it works only with segment indices. Each flow has a small record: the oldest unacknowledged segment (the base), the next never-sent segment, and three bitmaps of `MAP_W` bits indexed by offset from the base. The bitmaps mark a segment as acknowledged, as retransmitted, or as lost and waiting to be resent.

Three kinds of event change a flow. An acknowledgement event names a flow and a segment. A timeout event names a flow. A request asks for the next segment of a flow. The engine merges the acknowledgement and timeout updates for a flow into one state write. The request sees the result of that merge. The answer comes one cycle after the request: either a segment ID or an indication that nothing can be sent. Lost segments always win over new ones, and new segments may only run `WINDOW` segments ahead of the base.

The design has no state machine with sequential states. Each cycle is one merged update per flow. The only enumerated decision is the per-flow choice, which is one of `PICK_NONE`, `PICK_RTX` or `PICK_NEW`. Any decision leads back to the same single-cycle update on the next clock.

Top module: `seg_select_engine`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and at no other time. `rsp_none` is high only together with `rsp_valid`. Both are low after reset.
- R2: After reset every flow has base 0 and next segment 0. Requests that find no lost segment return new segment IDs 0, 1, 2, ... in order.
- R3: A new segment is returned only while (next − base) < `WINDOW` (default 8). If no segment is lost and the window is full, the response has `rsp_none` high.
- R4: An acknowledgement for a segment in [base, next) marks that segment as acknowledged. An acknowledgement outside that range has no effect. When the base segment is acknowledged, the base advances past every contiguous acknowledged segment.
- R5: When an acknowledgement arrives, a segment that has been sent, is unacknowledged and has never been retransmitted becomes lost if at least `DUP_THRESH` (default 3) segments above it are acknowledged.
- R6: A timeout for a flow marks every sent, unacknowledged segment of that flow as lost. This includes segments that were already retransmitted.
- R7: A request returns the lowest lost segment if one exists. Only when no segment is lost does it return a new segment.
- R8: Returning a lost segment clears its lost mark and sets its retransmitted mark. The segment is not returned again until it is marked lost again.
- R9: An acknowledgement and a timeout for the same flow in the same cycle are merged: the acknowledgement (with any slide) is applied first, then the timeout. A request for that flow in the same cycle sees the merged state.
- R10: Flows are independent. Events for one flow do not change the responses for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_valid | input | 1 | Acknowledgement event this cycle |
| ack_flow | input | FLOW_W | Flow of the acknowledgement |
| ack_seg | input | ID_W | Acknowledged segment ID |
| tmo_valid | input | 1 | Timeout event this cycle |
| tmo_flow | input | FLOW_W | Flow that timed out |
| req_valid | input | 1 | Next-segment request this cycle |
| req_flow | input | FLOW_W | Flow being asked for a segment |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_none | output | 1 | Nothing can be sent for that flow |
| rsp_seg | output | ID_W | Chosen segment ID (0 when `rsp_none`) |

## Verification
The bench checks the following corner cases and the failure each one would expose:
- **Window boundary.** A design that is off by one would send a ninth segment, or refuse the eighth.
- **Loss threshold.** With two acknowledged segments above a hole there must be no loss; with three there must be. A miscounted threshold retransmits too early or never.
- **Multi-segment slide.** The base must jump over a run of acknowledged segments. A design that slides by one would leave acknowledged segments inside the window and return wrong IDs.
- **Repeated timeout.** A second timeout must re-mark retransmitted segments. A design that only marks untouched segments would stall the flow.
- **Out-of-range acknowledgement.** It must be ignored. A design that accepts it would corrupt the bitmaps.
- **Retransmitted segment and acknowledgement loss.** Such a segment must not be marked lost again by acknowledgements.
- **Same-cycle events.** An acknowledgement, a timeout and a request in one cycle for one flow must merge. A design that drops one event, or answers from stale state, returns the wrong segment.

// File: rtl/seg_sel_pkg.sv
package seg_sel_pkg;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_RTX  = 2'd1,
        PICK_NEW  = 2'd2
    } pick_kind_t;

endpackage

// File: rtl/seg_loss_merge.sv
module seg_loss_merge #(
    parameter int ID_W       = 16,
    parameter int MAP_W      = 32,
    parameter int DUP_THRESH = 3
) (
    input  logic [ID_W-1:0]  base_i,
    input  logic [ID_W-1:0]  next_i,
    input  logic [MAP_W-1:0] acked_i,
    input  logic [MAP_W-1:0] lost_i,
    input  logic [MAP_W-1:0] rtx_i,
    input  logic             ack_hit,
    input  logic [ID_W-1:0]  ack_seg,
    input  logic             tmo_hit,
    output logic [ID_W-1:0]  base_o,
    output logic [MAP_W-1:0] acked_o,
    output logic [MAP_W-1:0] lost_o,
    output logic [MAP_W-1:0] rtx_o
);
    localparam int SH_W = $clog2(MAP_W + 1);

    logic [ID_W-1:0]  span, span_s, ack_off;
    logic             ack_ok, run;
    logic [MAP_W-1:0] acked_a, lost_a, fly_s, dup;
    logic [SH_W-1:0]  shift;

    always_comb begin
        // ack stage: mark the segment if it lies inside [base, next)
        span    = next_i - base_i;
        ack_off = ack_seg - base_i;
        ack_ok  = ack_hit && (ack_off < span);
        acked_a = acked_i;
        if (ack_ok) begin
            acked_a = acked_i | (MAP_W'(1) << ack_off);
        end
        lost_a = lost_i & ~acked_a;

        // slide length: run of acknowledged segments starting at the base
        shift = '0;
        run   = 1'b1;
        for (int i = 0; i < MAP_W; i++) begin
            if (run && acked_a[i]) begin
                shift = shift + 1'b1;
            end else begin
                run = 1'b0;
            end
        end

        acked_o = acked_a >> shift;
        rtx_o   = rtx_i >> shift;
        base_o  = base_i + ID_W'(shift);
        span_s  = span - ID_W'(shift);

        for (int i = 0; i < MAP_W; i++) begin
            fly_s[i] = ID_W'(i) < span_s;
        end

        // ack-driven loss: enough acknowledged segments above a hole
        for (int j = 0; j < MAP_W; j++) begin
            dup[j] = ack_ok && fly_s[j] && !acked_o[j] && !rtx_o[j] &&
                     ($countones(acked_o >> (j + 1)) >= DUP_THRESH);
        end

        // timeout stage applied after the ack stage
        lost_o = (lost_a >> shift) | dup;
        if (tmo_hit) begin
            lost_o = lost_o | (fly_s & ~acked_o);
        end
    end

endmodule

// File: rtl/seg_pick.sv
module seg_pick
    import seg_sel_pkg::*;
#(
    parameter int ID_W   = 16,
    parameter int MAP_W  = 32,
    parameter int WINDOW = 8
) (
    input  logic             req_hit,
    input  logic [ID_W-1:0]  base_i,
    input  logic [ID_W-1:0]  next_i,
    input  logic [MAP_W-1:0] lost_i,
    input  logic [MAP_W-1:0] rtx_i,
    output pick_kind_t       kind,
    output logic [ID_W-1:0]  seg,
    output logic [ID_W-1:0]  next_o,
    output logic [MAP_W-1:0] lost_o,
    output logic [MAP_W-1:0] rtx_o
);
    localparam int IDX_W = $clog2(MAP_W);

    logic [ID_W-1:0]  span;
    logic [MAP_W-1:0] grant;
    logic [IDX_W-1:0] idx;

    // decision: lost first, then new data inside the window
    always_comb begin
        span  = next_i - base_i;
        grant = lost_i & (~lost_i + 1'b1);
        idx   = '0;
        for (int i = MAP_W - 1; i >= 0; i--) begin
            if (lost_i[i]) begin
                idx = IDX_W'(i);
            end
        end
        if (|lost_i) begin
            kind = PICK_RTX;
        end else if (span < ID_W'(WINDOW)) begin
            kind = PICK_NEW;
        end else begin
            kind = PICK_NONE;
        end
    end

    // result and commit for each decision
    always_comb begin
        seg    = '0;
        next_o = next_i;
        lost_o = lost_i;
        rtx_o  = rtx_i;
        unique case (kind)
            PICK_RTX: begin
                seg = base_i + ID_W'(idx);
                if (req_hit) begin
                    lost_o = lost_i & ~grant;
                    rtx_o  = rtx_i | grant;
                end
            end
            PICK_NEW: begin
                seg = next_i;
                if (req_hit) begin
                    next_o = next_i + 1'b1;
                end
            end
            PICK_NONE: begin
                seg = '0;
            end
            default: begin
                seg = '0;
            end
        endcase
    end

endmodule

// File: rtl/seg_flow_lane.sv
module seg_flow_lane
    import seg_sel_pkg::*;
#(
    parameter int ID_W       = 16,
    parameter int MAP_W      = 32,
    parameter int WINDOW     = 8,
    parameter int DUP_THRESH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_hit,
    input  logic [ID_W-1:0] ack_seg,
    input  logic            tmo_hit,
    input  logic            req_hit,
    output pick_kind_t      kind,
    output logic [ID_W-1:0] seg
);
    logic [ID_W-1:0]  base_q, next_q, base_m, next_n;
    logic [MAP_W-1:0] acked_q, lost_q, rtx_q;
    logic [MAP_W-1:0] acked_m, lost_m, rtx_m, lost_n, rtx_n;
    logic [MAP_W-1:0] fly_q;
    logic [ID_W-1:0]  span_q;

    seg_loss_merge #(.ID_W(ID_W), .MAP_W(MAP_W), .DUP_THRESH(DUP_THRESH)) u_merge (
        .base_i (base_q),
        .next_i (next_q),
        .acked_i(acked_q),
        .lost_i (lost_q),
        .rtx_i  (rtx_q),
        .ack_hit(ack_hit),
        .ack_seg(ack_seg),
        .tmo_hit(tmo_hit),
        .base_o (base_m),
        .acked_o(acked_m),
        .lost_o (lost_m),
        .rtx_o  (rtx_m)
    );

    seg_pick #(.ID_W(ID_W), .MAP_W(MAP_W), .WINDOW(WINDOW)) u_pick (
        .req_hit(req_hit),
        .base_i (base_m),
        .next_i (next_q),
        .lost_i (lost_m),
        .rtx_i  (rtx_m),
        .kind   (kind),
        .seg    (seg),
        .next_o (next_n),
        .lost_o (lost_n),
        .rtx_o  (rtx_n)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            next_q  <= '0;
            acked_q <= '0;
            lost_q  <= '0;
            rtx_q   <= '0;
        end else begin
            base_q  <= base_m;
            next_q  <= next_n;
            acked_q <= acked_m;
            lost_q  <= lost_n;
            rtx_q   <= rtx_n;
        end
    end

    always_comb begin
        span_q = next_q - base_q;
        for (int i = 0; i < MAP_W; i++) begin
            fly_q[i] = ID_W'(i) < span_q;
        end
    end

    // R3: the sent span never exceeds the window
    p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        span_q <= ID_W'(WINDOW));

    // R4: the base segment is never left acknowledged after a slide
    p_base_unacked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !acked_q[0]);

    // R4: an acknowledged segment never stays marked lost
    p_lost_clear_of_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_q & acked_q) == '0);

    // R6: status marks exist only for sent segments
    p_marks_in_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((acked_q | lost_q | rtx_q) & ~fly_q) == '0);

    // R7: new data is chosen only when the merged state has no lost segment
    p_new_only_without_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && kind == PICK_NEW) |-> (lost_m == '0));

    // R8: a retransmission leaves a retransmitted mark behind
    p_rtx_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && kind == PICK_RTX) |=> (rtx_q != '0));

endmodule

// File: rtl/seg_select_engine.sv
module seg_select_engine
    import seg_sel_pkg::*;
#(
    parameter int NUM_FLOWS  = 4,
    parameter int FLOW_W     = $clog2(NUM_FLOWS),
    parameter int ID_W       = 16,
    parameter int MAP_W      = 32,
    parameter int WINDOW     = 8,
    parameter int DUP_THRESH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_valid,
    input  logic [FLOW_W-1:0] ack_flow,
    input  logic [ID_W-1:0]   ack_seg,
    input  logic              tmo_valid,
    input  logic [FLOW_W-1:0] tmo_flow,
    input  logic              req_valid,
    input  logic [FLOW_W-1:0] req_flow,
    output logic              rsp_valid,
    output logic              rsp_none,
    output logic [ID_W-1:0]   rsp_seg
);
    pick_kind_t      lane_kind [NUM_FLOWS];
    logic [ID_W-1:0] lane_seg  [NUM_FLOWS];
    pick_kind_t      sel_kind;
    logic [ID_W-1:0] sel_seg;

    for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_lane
        seg_flow_lane #(
            .ID_W(ID_W), .MAP_W(MAP_W), .WINDOW(WINDOW), .DUP_THRESH(DUP_THRESH)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ack_hit(ack_valid && (ack_flow == FLOW_W'(f))),
            .ack_seg(ack_seg),
            .tmo_hit(tmo_valid && (tmo_flow == FLOW_W'(f))),
            .req_hit(req_valid && (req_flow == FLOW_W'(f))),
            .kind   (lane_kind[f]),
            .seg    (lane_seg[f])
        );
    end

    always_comb begin
        sel_kind = lane_kind[req_flow];
        sel_seg  = lane_seg[req_flow];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_none  <= 1'b0;
            rsp_seg   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_none  <= req_valid && (sel_kind == PICK_NONE);
            rsp_seg   <= (req_valid && sel_kind != PICK_NONE) ? sel_seg : '0;
        end
    end

    // R1: a response only follows a request
    p_rsp_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R1: the empty indication never appears without a response
    p_none_with_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_none |-> rsp_valid);

endmodule

// File: tb/sim_seg_select_engine.sv
`timescale 1ns/1ps
module sim_seg_select_engine;
    localparam int FW = 2;
    localparam int IW = 16;
    localparam logic [1:0] OQ = 2'd0;
    localparam logic [1:0] OA = 2'd1;
    localparam logic [1:0] OT = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  flow;
        logic [15:0] seg;
        logic        none;
        logic [15:0] eseg;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd0},   // R2
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd1},   // R2
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd2},   // R2
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd3},   // R2
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd4},   // R2
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd5},   // R2
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd6},   // R2
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd7},   // R3 last slot
        '{OQ, 2'd0, 16'd0,   1'b1, 16'd0},   // R3 window full
        '{OA, 2'd0, 16'd0,   1'b0, 16'd0},   // R4 slide by one
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd8},   // R4 window reopened
        '{OQ, 2'd0, 16'd0,   1'b1, 16'd0},   // R3
        '{OA, 2'd0, 16'd2,   1'b0, 16'd0},   // R5
        '{OA, 2'd0, 16'd3,   1'b0, 16'd0},   // R5
        '{OQ, 2'd0, 16'd0,   1'b1, 16'd0},   // R5 two above: no loss
        '{OA, 2'd0, 16'd4,   1'b0, 16'd0},   // R5 third above
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd1},   // R5 R7 lost seg 1
        '{OQ, 2'd0, 16'd0,   1'b1, 16'd0},   // R8 not picked twice
        '{OA, 2'd0, 16'd1,   1'b0, 16'd0},   // R4 slide over 1..4
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd9},   // R4 base now 5
        '{OT, 2'd0, 16'd0,   1'b0, 16'd0},   // R6
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd5},   // R6 R7
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd6},   // R7
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd7},   // R7
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd8},   // R7
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd9},   // R7
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd10},  // R7 new after lost drained
        '{OT, 2'd0, 16'd0,   1'b0, 16'd0},   // R6 second timeout
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd5},   // R6 retransmitted re-lost
        '{OA, 2'd0, 16'd100, 1'b0, 16'd0},   // R4 out of range
        '{OQ, 2'd0, 16'd0,   1'b0, 16'd6},   // R4 ignored ack
        '{OQ, 2'd1, 16'd0,   1'b0, 16'd0}    // R10 other flow untouched
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ack_valid = 1'b0;
    logic [FW-1:0] ack_flow = '0;
    logic [IW-1:0] ack_seg = '0;
    logic          tmo_valid = 1'b0;
    logic [FW-1:0] tmo_flow = '0;
    logic          req_valid = 1'b0;
    logic [FW-1:0] req_flow = '0;
    logic          rsp_valid, rsp_none;
    logic [IW-1:0] rsp_seg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_select_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .ack_valid(ack_valid), .ack_flow(ack_flow), .ack_seg(ack_seg),
        .tmo_valid(tmo_valid), .tmo_flow(tmo_flow),
        .req_valid(req_valid), .req_flow(req_flow),
        .rsp_valid(rsp_valid), .rsp_none(rsp_none), .rsp_seg(rsp_seg)
    );

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual valid/none/seg=%0b/%0b/%0d expected %0b/%0b/%0d",
                     tag, act[17], act[16], act[15:0], exp[17], exp[16], exp[15:0]);
        end
    endtask

    // one cycle of stimulus, sampled at the following falling edge
    task automatic cyc(input logic av, input logic [FW-1:0] af, input logic [IW-1:0] as,
                       input logic tv, input logic [FW-1:0] tf,
                       input logic rv, input logic [FW-1:0] rf);
        ack_valid = av; ack_flow = af; ack_seg = as;
        tmo_valid = tv; tmo_flow = tf;
        req_valid = rv; req_flow = rf;
        @(negedge clk);
        ack_valid = 1'b0; tmo_valid = 1'b0; req_valid = 1'b0;
    endtask

    task automatic req_expect(input string tag, input logic [FW-1:0] f,
                              input logic none, input logic [IW-1:0] s);
        cyc(1'b0, '0, '0, 1'b0, '0, 1'b1, f);
        check(tag, {rsp_valid, rsp_none, rsp_seg}, {1'b1, none, s});
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {rsp_valid, rsp_none, rsp_seg}, 18'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {rsp_valid, rsp_none, rsp_seg}, 18'd0);

        // table walk on flows 0 and 1
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VEC[i];
            $sformat(tag, "table step %0d", i);
            if (v.op == OQ) begin
                req_expect(tag, v.flow, v.none, v.eseg);
            end else begin
                cyc(v.op == OA, v.flow, v.seg, v.op == OT, v.flow, 1'b0, '0);
                check({tag, " R1 no response"}, {rsp_valid, rsp_none, rsp_seg}, 18'd0);
            end
        end

        // R10: flow 1 continues from its own state
        req_expect("R10 flow1 second", 2'd1, 1'b0, 16'd1);

        // R9: ack and timeout to one flow in one cycle
        for (int k = 0; k < 4; k++) req_expect("R2 flow2 fill", 2'd2, 1'b0, IW'(k));
        cyc(1'b1, 2'd2, 16'd0, 1'b1, 2'd2, 1'b0, '0);
        req_expect("R9 merged ack then timeout", 2'd2, 1'b0, 16'd1);
        req_expect("R9 second lost", 2'd2, 1'b0, 16'd2);
        req_expect("R9 third lost", 2'd2, 1'b0, 16'd3);
        // R5: segment 1 retransmitted, acks above it must not re-mark it
        cyc(1'b1, 2'd2, 16'd2, 1'b0, '0, 1'b0, '0);
        cyc(1'b1, 2'd2, 16'd3, 1'b0, '0, 1'b0, '0);
        req_expect("R5 new while hole pending", 2'd2, 1'b0, 16'd4);
        cyc(1'b1, 2'd2, 16'd4, 1'b0, '0, 1'b0, '0);
        req_expect("R5 retransmitted not re-lost", 2'd2, 1'b0, 16'd5);

        // R9: request in the same cycle as a timeout sees the timeout
        req_expect("R2 flow3 first", 2'd3, 1'b0, 16'd0);
        cyc(1'b0, '0, '0, 1'b1, 2'd3, 1'b1, 2'd3);
        check("R9 request sees timeout", {rsp_valid, rsp_none, rsp_seg}, {1'b1, 1'b0, 16'd0});
        req_expect("R8 then new data", 2'd3, 1'b0, 16'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule